// File: doc/BRIEF.md
# Jump Target Resolver

This block turns the 6-bit destination operand of a jump or subroutine-call instruction into the address that control transfers to. A one-cycle start pulse hands it the operand. The top three bits pick an addressing mode and the low three bits pick one of eight general registers, with register 7 acting as the program counter.

The block reads and updates the register file through one read port and one write port. When a mode needs it, the block fetches an index extension word or a pointer word through a single-outstanding memory read port. It finishes with a one-cycle done pulse and the resolved target. If the mode is register-direct it raises an illegal-instruction trap instead, and if the resolved target is odd it raises an odd-address trap.

Decoding the surrounding instruction, saving the return linkage and vectoring traps are handled by neighbouring logic.

Top module: `jmp_target_resolver`

## Requirements
- R1: Mode code 0 (operand bits 5..3 = 000) raises trap_illegal_o for one cycle in the cycle after start, with no done_o, no memory request and no register write.
- R2: Mode code 1 gives a target equal to the selected register, and leaves the register unchanged.
- R3: Mode code 2 gives a target equal to the selected register's old value, and then adds 2 to that register.
- R4: Mode code 3 reads the memory word whose address is the register's old value and uses it as the target; the register is increased by 2. On register 7 this gives an absolute target taken from the word after the instruction.
- R5: Mode code 4 subtracts 2 from the register and uses the new value as the target.
- R6: Mode code 5 subtracts 2 from the register and uses the memory word at the new value as the target.
- R7: Mode code 6 reads an extension word at the address held in register 7 and adds 2 to register 7. It then adds the extension word to the selected register, as read after that update, modulo 2^16. On register 7 the offset therefore counts from the word after the extension.
- R8: Mode code 7 forms the same sum as mode 6 and uses the memory word at that sum as the target.
- R9: A resolved target with bit 0 set raises trap_odd_o for one cycle, with no done_o, and target_o keeps its previous value. Any register update of the mode has still taken place.
- R10: Only one memory read is outstanding: mem_req_o and mem_addr_o stay unchanged until mem_rvalid_i, and the read data is taken in that cycle.
- R11: A start pulse that arrives while a resolution is in progress is ignored.
- R12: done_o, trap_illegal_o and trap_odd_o each last one cycle and are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving dst_i |
| dst_i | input | 6 | Destination operand: mode in 5..3, register in 2..0 |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 16 | Register file read data, same cycle |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | 16 | Register file write data |
| mem_req_o | output | 1 | Memory read request, held until valid |
| mem_addr_o | output | 16 | Memory read byte address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 16 | Memory read data |
| done_o | output | 1 | Target resolved, one cycle |
| target_o | output | 16 | Last resolved target |
| trap_illegal_o | output | 1 | Register-direct mode trap, one cycle |
| trap_odd_o | output | 1 | Odd target trap, one cycle |

## Verification
The assertions assume that the memory side raises mem_rvalid_i only while mem_req_o is high, gives exactly one response per request, and keeps its data valid in the response cycle. They also assume that the register file returns the addressed word in the same cycle and that a write becomes visible from the next cycle on. The bench models the register file and memory under exactly those rules. Its memory answers each request once, after a latency set per vector between zero and four cycles, and it issues a start pulse only while the block is idle, apart from the one test that sends a second start on purpose.

// File: rtl/jtr_pkg.sv
package jtr_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXT  = 2'd1,
    S_CALC = 2'd2,
    S_PTR  = 2'd3
  } jtr_state_e;

  localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/jtr_mode_dec.sv
module jtr_mode_dec
  import jtr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              illegal_o,
  output logic              need_ext_o,
  output logic              mem_ptr_o,
  output logic              post_inc_o,
  output logic              pre_dec_o,
  output logic              indexed_o
);
  logic [1:0] kind;
  logic       defer;

  assign kind  = mode_i[2:1];
  assign defer = mode_i[0];

  always_comb begin
    illegal_o  = (kind == 2'b00) && !defer;
    post_inc_o = (kind == 2'b01);
    pre_dec_o  = (kind == 2'b10);
    indexed_o  = (kind == 2'b11);
    need_ext_o = indexed_o;
    // deferred on plain register mode is a direct target, no pointer read
    mem_ptr_o  = defer && (kind != 2'b00);
  end
endmodule

// File: rtl/jtr_ea_unit.sv
module jtr_ea_unit #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              post_inc_i,
  input  logic              pre_dec_i,
  input  logic              indexed_i,
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [DATA_W-1:0] ext_i,
  output logic [DATA_W-1:0] ea_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_val_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(2);

  logic [DATA_W-1:0] inc_v, dec_v, sum_v;

  assign inc_v = reg_val_i + STEP;
  assign dec_v = reg_val_i - STEP;
  assign sum_v = reg_val_i + ext_i;

  always_comb begin
    if (indexed_i)      ea_o = sum_v;
    else if (pre_dec_i) ea_o = dec_v;
    else                ea_o = reg_val_i;
    wb_en_o  = post_inc_i || pre_dec_i;
    wb_val_o = pre_dec_i ? dec_v : inc_v;
  end
endmodule

// File: rtl/jtr_seq.sv
module jtr_seq
  import jtr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RSEL_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [MODE_W+RSEL_W-1:0] dst_i,
  input  logic                     illegal_i,
  input  logic                     need_ext_i,
  input  logic                     mem_ptr_i,
  input  logic                     wb_en_i,
  input  logic [DATA_W-1:0]        wb_val_i,
  input  logic [DATA_W-1:0]        ea_i,
  input  logic [DATA_W-1:0]        rf_rdata_i,
  input  logic                     mem_rvalid_i,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic                     busy_o,
  output logic [MODE_W-1:0]        mode_o,
  output logic [DATA_W-1:0]        ext_o,
  output logic [RSEL_W-1:0]        rf_raddr_o,
  output logic                     rf_we_o,
  output logic [RSEL_W-1:0]        rf_waddr_o,
  output logic [DATA_W-1:0]        rf_wdata_o,
  output logic                     mem_req_o,
  output logic [DATA_W-1:0]        mem_addr_o,
  output logic                     done_o,
  output logic [DATA_W-1:0]        target_o,
  output logic                     trap_illegal_o,
  output logic                     trap_odd_o
);
  localparam int unsigned          DST_W = MODE_W + RSEL_W;
  localparam logic [RSEL_W-1:0]    PC_IDX = RSEL_W'((1 << RSEL_W) - 1);
  localparam logic [DATA_W-1:0]    STEP = DATA_W'(2);

  jtr_state_e        state_q;
  logic [DST_W-1:0]  dst_q;
  logic [DATA_W-1:0] ext_q, ptr_q, target_q;
  logic              done_q, trap_ill_q, trap_odd_q;
  logic [RSEL_W-1:0] reg_sel;

  assign reg_sel = dst_q[RSEL_W-1:0];
  assign busy_o  = (state_q != S_IDLE);
  assign mode_o  = dst_q[DST_W-1 -: MODE_W];
  assign ext_o   = ext_q;

  always_comb begin
    rf_raddr_o = (state_q == S_EXT) ? PC_IDX : reg_sel;
    mem_req_o  = (state_q == S_EXT) || (state_q == S_PTR);
    mem_addr_o = (state_q == S_EXT) ? rf_rdata_i : ptr_q;
    rf_we_o    = ((state_q == S_EXT) && mem_rvalid_i) ||
                 ((state_q == S_CALC) && wb_en_i);
    rf_waddr_o = (state_q == S_EXT) ? PC_IDX : reg_sel;
    // PC steps past the extension word before the index is added
    rf_wdata_o = (state_q == S_EXT) ? (rf_rdata_i + STEP) : wb_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      dst_q      <= '0;
      ext_q      <= '0;
      ptr_q      <= '0;
      target_q   <= '0;
      done_q     <= 1'b0;
      trap_ill_q <= 1'b0;
      trap_odd_q <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      trap_ill_q <= 1'b0;
      trap_odd_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            dst_q <= dst_i;
            if (illegal_i)       trap_ill_q <= 1'b1;
            else if (need_ext_i) state_q    <= S_EXT;
            else                 state_q    <= S_CALC;
          end
        end
        S_EXT: begin
          if (mem_rvalid_i) begin
            ext_q   <= mem_rdata_i;
            state_q <= S_CALC;
          end
        end
        S_CALC: begin
          if (mem_ptr_i) begin
            ptr_q   <= ea_i;
            state_q <= S_PTR;
          end else begin
            state_q <= S_IDLE;
            if (ea_i[0]) trap_odd_q <= 1'b1;
            else begin
              done_q   <= 1'b1;
              target_q <= ea_i;
            end
          end
        end
        S_PTR: begin
          if (mem_rvalid_i) begin
            state_q <= S_IDLE;
            if (mem_rdata_i[0]) trap_odd_q <= 1'b1;
            else begin
              done_q   <= 1'b1;
              target_q <= mem_rdata_i;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o         = done_q;
  assign target_o       = target_q;
  assign trap_illegal_o = trap_ill_q;
  assign trap_odd_o     = trap_odd_q;
endmodule

// File: rtl/jmp_target_resolver.sv
module jmp_target_resolver
  import jtr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RSEL_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [MODE_W+RSEL_W-1:0] dst_i,
  output logic [RSEL_W-1:0]        rf_raddr_o,
  input  logic [DATA_W-1:0]        rf_rdata_i,
  output logic                     rf_we_o,
  output logic [RSEL_W-1:0]        rf_waddr_o,
  output logic [DATA_W-1:0]        rf_wdata_o,
  output logic                     mem_req_o,
  output logic [DATA_W-1:0]        mem_addr_o,
  input  logic                     mem_rvalid_i,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic                     done_o,
  output logic [DATA_W-1:0]        target_o,
  output logic                     trap_illegal_o,
  output logic                     trap_odd_o
);
  localparam int unsigned DST_W = MODE_W + RSEL_W;

  logic              busy;
  logic [MODE_W-1:0] mode_q, mode_sel;
  logic              illegal, need_ext, mem_ptr, post_inc, pre_dec, indexed;
  logic              wb_en;
  logic [DATA_W-1:0] wb_val, ea, ext;

  // idle decodes the incoming operand, busy decodes the captured one
  assign mode_sel = busy ? mode_q : dst_i[DST_W-1 -: MODE_W];

  jtr_mode_dec u_dec (
    .mode_i     (mode_sel),
    .illegal_o  (illegal),
    .need_ext_o (need_ext),
    .mem_ptr_o  (mem_ptr),
    .post_inc_o (post_inc),
    .pre_dec_o  (pre_dec),
    .indexed_o  (indexed)
  );

  jtr_ea_unit #(.DATA_W(DATA_W)) u_ea (
    .post_inc_i (post_inc),
    .pre_dec_i  (pre_dec),
    .indexed_i  (indexed),
    .reg_val_i  (rf_rdata_i),
    .ext_i      (ext),
    .ea_o       (ea),
    .wb_en_o    (wb_en),
    .wb_val_o   (wb_val)
  );

  jtr_seq #(.DATA_W(DATA_W), .RSEL_W(RSEL_W)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .dst_i          (dst_i),
    .illegal_i      (illegal),
    .need_ext_i     (need_ext),
    .mem_ptr_i      (mem_ptr),
    .wb_en_i        (wb_en),
    .wb_val_i       (wb_val),
    .ea_i           (ea),
    .rf_rdata_i     (rf_rdata_i),
    .mem_rvalid_i   (mem_rvalid_i),
    .mem_rdata_i    (mem_rdata_i),
    .busy_o         (busy),
    .mode_o         (mode_q),
    .ext_o          (ext),
    .rf_raddr_o     (rf_raddr_o),
    .rf_we_o        (rf_we_o),
    .rf_waddr_o     (rf_waddr_o),
    .rf_wdata_o     (rf_wdata_o),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .done_o         (done_o),
    .target_o       (target_o),
    .trap_illegal_o (trap_illegal_o),
    .trap_odd_o     (trap_odd_o)
  );
endmodule

// File: rtl/jtr_checker.sv
module jtr_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DST_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DST_W-1:0]  dst_i,
  input logic              busy_i,
  input logic              rf_we_i,
  input logic              mem_req_i,
  input logic [DATA_W-1:0] mem_addr_i,
  input logic              mem_rvalid_i,
  input logic              done_i,
  input logic [DATA_W-1:0] target_i,
  input logic              trap_illegal_i,
  input logic              trap_odd_i
);
  a_r1_illegal_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && (dst_i[DST_W-1 -: 3] == 3'd0)
    |=> trap_illegal_i && !busy_i && !mem_req_i && !rf_we_i);

  a_r9_even_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !target_i[0]);

  a_r9_odd_keeps_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_odd_i |-> $stable(target_i));

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_rvalid_i |=> mem_req_i && $stable(mem_addr_i));

  a_r10_rvalid_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> mem_req_i);

  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({done_i, trap_illegal_i, trap_odd_i}) <= 1);

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r12_odd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_odd_i |=> !trap_odd_i);
endmodule

bind jmp_target_resolver jtr_checker #(.DATA_W(DATA_W), .DST_W(MODE_W + RSEL_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .dst_i          (dst_i),
  .busy_i         (busy),
  .rf_we_i        (rf_we_o),
  .mem_req_i      (mem_req_o),
  .mem_addr_i     (mem_addr_o),
  .mem_rvalid_i   (mem_rvalid_i),
  .done_i         (done_o),
  .target_i       (target_o),
  .trap_illegal_i (trap_illegal_o),
  .trap_odd_i     (trap_odd_o)
);

// File: tb/jmp_target_resolver_bench.sv
module jmp_target_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PC_INIT = 16'h0200;

  typedef struct packed {
    logic [5:0]  dst;
    logic [15:0] rv;
    logic [15:0] tgt;
    logic [15:0] ra;
    logic [15:0] pc;
    logic [1:0]  kind;   // 0 done, 1 illegal, 2 odd
    logic [2:0]  lat;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{6'o12, 16'h0400, 16'h0400, 16'h0400, 16'h0200, 2'd0, 3'd0},  // R2
    '{6'o23, 16'h0500, 16'h0500, 16'h0502, 16'h0200, 2'd0, 3'd1},  // R3
    '{6'o31, 16'h0600, 16'h1600, 16'h0602, 16'h0200, 2'd0, 3'd2},  // R4
    '{6'o44, 16'h0700, 16'h06FE, 16'h06FE, 16'h0200, 2'd0, 3'd0},  // R5
    '{6'o55, 16'h0800, 16'h17FE, 16'h07FE, 16'h0200, 2'd0, 3'd3},  // R6
    '{6'o61, 16'h0100, 16'h1300, 16'h0100, 16'h0202, 2'd0, 3'd1},  // R7
    '{6'o72, 16'h0010, 16'h2210, 16'h0010, 16'h0202, 2'd0, 3'd2},  // R8
    '{6'o67, 16'h0200, 16'h1402, 16'h0202, 16'h0202, 2'd0, 3'd0},  // R7 pc-relative
    '{6'o37, 16'h0200, 16'h1200, 16'h0202, 16'h0202, 2'd0, 3'd1},  // R4 absolute
    '{6'o03, 16'h0500, 16'h0000, 16'h0500, 16'h0200, 2'd1, 3'd0},  // R1
    '{6'o16, 16'h0301, 16'h0000, 16'h0301, 16'h0200, 2'd2, 3'd0},  // R9
    '{6'o32, 16'h0300, 16'h0000, 16'h0302, 16'h0200, 2'd2, 3'd1},  // R9 via pointer
    '{6'o63, 16'hFE00, 16'h1000, 16'hFE00, 16'h0202, 2'd0, 3'd0},  // R7 wrap
    '{6'o40, 16'h0000, 16'hFFFE, 16'hFFFE, 16'h0200, 2'd0, 3'd2}   // R5 wrap
  };

  logic        clk, rst_n, start;
  logic [5:0]  dst;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_rdata, target;
  logic        rf_we, mem_req, mem_rvalid, done, trap_ill, trap_odd;
  logic [15:0] rf [8];
  logic [2:0]  lat, lat_cnt;
  int          checks, errors;
  bit          finished;

  jmp_target_resolver u_jmp_target_resolver (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dst_i(dst),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .done_o(done), .target_o(target),
    .trap_illegal_o(trap_ill), .trap_odd_o(trap_odd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    if (a == 16'h0300) return 16'h0123;
    return a + 16'h1000;
  endfunction

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; lat_cnt <= '0; mem_rdata <= '0;
    end else if (mem_req && !mem_rvalid) begin
      if (lat_cnt == lat) begin
        mem_rvalid <= 1'b1; mem_rdata <= mem_fn(mem_addr); lat_cnt <= '0;
      end else lat_cnt <= lat_cnt + 3'd1;
    end else mem_rvalid <= 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_regs(input logic [2:0] sel, input logic [15:0] rv);
    for (int i = 0; i < 8; i++) rf[i] = 16'h0A00 + 16'(i * 16);
    rf[7] = PC_INIT;
    rf[sel] = rv;
  endtask

  // waits for an outcome; returns {done,ill,odd}, flags any memory request / stall violation
  task automatic wait_outcome(output logic [2:0] flags, output bit saw_req);
    logic        prev_wait = 1'b0;
    logic [15:0] prev_addr = '0;
    flags = '0; saw_req = 0;
    for (int n = 0; n < 60; n++) begin
      if (prev_wait) begin
        chk("R10 req held", {15'd0, mem_req}, 32'd1);
        chk("R10 addr stable", {16'd0, mem_addr}, {16'd0, prev_addr});
      end
      if (mem_req) saw_req = 1;
      prev_wait = mem_req && !mem_rvalid;
      prev_addr = mem_addr;
      flags = {done, trap_ill, trap_odd};
      if (flags != 3'b000) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [2:0]  flags;
    logic [15:0] last_tgt;
    bit          saw_req;
    checks = 0; errors = 0; finished = 0;
    start = 1'b0; dst = '0; lat = '0;
    init_regs(3'd0, 16'h0A00);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk("reset done", {31'd0, done}, 32'd0);
    chk("reset traps", {30'd0, trap_ill, trap_odd}, 32'd0);
    chk("reset req", {31'd0, mem_req}, 32'd0);
    chk("reset target", {16'd0, target}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    last_tgt = '0;

    for (int v = 0; v < NV; v++) begin
      logic [2:0] ef;
      string tag;
      tag = $sformatf("vec%0d R2-R9", v);
      ef = (VEC[v].kind == 2'd0) ? 3'b100 : (VEC[v].kind == 2'd1) ? 3'b010 : 3'b001;
      lat = VEC[v].lat;
      init_regs(VEC[v].dst[2:0], VEC[v].rv);
      dst = VEC[v].dst; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_outcome(flags, saw_req);
      chk({tag, " outcome"}, {29'd0, flags}, {29'd0, ef});
      if (VEC[v].kind == 2'd0) begin
        chk({tag, " target"}, {16'd0, target}, {16'd0, VEC[v].tgt});
        last_tgt = VEC[v].tgt;
      end else
        chk({tag, " R9 target kept"}, {16'd0, target}, {16'd0, last_tgt});
      if (VEC[v].kind == 2'd1) chk("R1 no mem req", {31'd0, saw_req}, 32'd0);
      @(negedge clk);
      chk("R12 single pulse", {29'd0, done, trap_ill, trap_odd}, 32'd0);
      chk({tag, " reg after"}, {16'd0, rf[VEC[v].dst[2:0]]}, {16'd0, VEC[v].ra});
      chk({tag, " pc after"}, {16'd0, rf[7]}, {16'd0, VEC[v].pc});
    end

    // R11: second start during a pointer fetch is ignored
    lat = 3'd4;
    init_regs(3'd1, 16'h0600);
    dst = 6'o31; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    dst = 6'o02; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_outcome(flags, saw_req);
    chk("R11 outcome", {29'd0, flags}, 32'b100);
    chk("R11 target", {16'd0, target}, 32'h1600);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 no extra outcome", {29'd0, done, trap_ill, trap_odd}, 32'd0);
    end
    chk("R11 R2 untouched", {16'd0, rf[2]}, 32'h0A20);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule